// File: doc/BRIEF.md
# Storage Timeout Error-Recovery Sequencer

This block brings a card-attached ATA device back into service after a command or data timeout. When a timeout event arrives while it is idle, it sends a chain of recovery commands through a simple issue handshake. The handshake carries a command index, an argument and a one-cycle start strobe out, and takes response-valid, response-ok and response-timeout strobes back. The chain escalates as each step succeeds or fails. An optional completion-signal disable comes first. Stop-transmission follows, then a fast-I/O soft reset. A hard go-idle reset is the last resort.

Each step is guarded by its own response timer, which is reloaded from a programmable limit on every command start. A clean finish produces a one-cycle ready pulse. A finish through the hard reset produces a one-cycle re-initialization-required pulse, because every device setting is lost. An ATA-level error with no protocol fault starts no recovery. It only yields a retry-permitted pulse.

Top module: `tmo_recovery_seq`

## Requirements
- R1: After reset, `busy`, `cmd_start`, `dev_ready`, `reinit_req` and `retry_ok` are all low.
- R2: A `tmo_evt` seen while idle with `ien_n`=0 and `blk_rsp_seen`=1 makes the first command index IDX_CCSD (default 60), followed by 12 once that command gets an ok response.
- R3: A `tmo_evt` seen while idle under any other flag combination makes the first command index 12 (stop-transmission).
- R4: An ok response to command 12 is followed by command 39 with argument ARG_FIO (default 4). Every other command carries argument 0.
- R5: An ok response to command 39 gives a one-cycle `dev_ready` pulse in the cycle after the response.
- R6: A response with `rsp_ok`=0, a `rsp_tmo` strobe, or an expired step timer during any step other than the hard reset makes the next command index 0. In the cycle after the start of command 0, `reinit_req` pulses for one cycle.
- R7: The step timer is reloaded from `step_limit` when each command starts. If no response arrives within `step_limit` cycles after the start cycle, the step fails. With `step_limit`=0, command 0 starts exactly two cycles after the start of the silent command.
- R8: A further `tmo_evt` while any step before the hard reset is under way escalates directly to command 0.
- R9: `ata_fail` while idle with no `tmo_evt` gives a one-cycle `retry_ok` pulse in the next cycle and issues no command. While `busy` is high, `ata_fail` has no effect.
- R10: `busy` is high from the cycle of the first `cmd_start` through the cycle of the final `dev_ready` or `reinit_req` pulse, and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_evt | input | 1 | Timeout event strobe |
| ien_n | input | 1 | Completion-interrupt disable flag (0 = interrupts enabled) |
| blk_rsp_seen | input | 1 | Response to the multiple-block command had arrived |
| ata_fail | input | 1 | ATA status error with all commands completed |
| step_limit | input | TW | Per-step response timeout in cycles |
| cmd_idx | output | IDX_W | Command index to issue |
| cmd_arg | output | ARG_W | Command argument |
| cmd_start | output | 1 | One-cycle command start strobe |
| rsp_valid | input | 1 | Response received |
| rsp_ok | input | 1 | Received response is good |
| rsp_tmo | input | 1 | Command engine reports a response timeout |
| busy | output | 1 | Recovery sequence in progress |
| dev_ready | output | 1 | Pulse: device ready for ATA commands again |
| reinit_req | output | 1 | Pulse: full device re-initialization required |
| retry_ok | output | 1 | Pulse: ATA command may be retried |

## Verification
A wrong state register shows at the ports within one cycle. It surfaces as an unexpected command index, or as a `cmd_start` in a cycle where a wait was due. A lost transition shows as a chain ending in `reinit_req` instead of `dev_ready`. A wrong timer reload or compare shifts the cycle count between two starts, so the gap from a silent step to command 0 is measured exactly. Stale `busy` or pulse widths show on the cycle after the final pulse.

// File: rtl/rec_pkg.sv
package rec_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_CCSD_I, ST_CCSD_W, ST_STOP_I, ST_STOP_W,
      ST_FIO_I, ST_FIO_W, ST_HARD_I, ST_READY_F, ST_REINIT_F
   } rec_state_e;
endpackage

// File: rtl/rec_step_timer.sv
module rec_step_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] limit,
   input  logic          run,
   output logic          expired
);
   generate
      if (TW < 1 || TW > 32) begin : g_bad_tw
         $error("rec_step_timer: TW out of range");
      end
   endgenerate

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (load)               cnt_q <= limit;
      else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/rec_cmd_select.sv
module rec_cmd_select
   import rec_pkg::*;
#(
   parameter int          IDX_W    = 6,
   parameter int          ARG_W    = 32,
   parameter int          IDX_CCSD = 60,
   parameter int          IDX_STOP = 12,
   parameter int          IDX_FIO  = 39,
   parameter int          IDX_IDLE = 0,
   parameter logic [31:0] ARG_FIO  = 32'd4
) (
   input  rec_state_e       st,
   output logic [IDX_W-1:0] idx,
   output logic [ARG_W-1:0] arg,
   output logic             start
);
   localparam int IDX_MAX = (1 << IDX_W) - 1;

   generate
      if (IDX_CCSD > IDX_MAX || IDX_STOP > IDX_MAX || IDX_FIO > IDX_MAX || IDX_IDLE > IDX_MAX) begin : g_bad_idx
         $error("rec_cmd_select: command index does not fit IDX_W");
      end
      if (ARG_W < 1 || ARG_W > 32) begin : g_bad_arg
         $error("rec_cmd_select: ARG_W out of range");
      end
   endgenerate

   always_comb begin
      idx   = IDX_W'(IDX_IDLE);
      arg   = '0;
      start = 1'b0;
      unique case (st)
         ST_CCSD_I: begin idx = IDX_W'(IDX_CCSD); start = 1'b1; end
         ST_STOP_I: begin idx = IDX_W'(IDX_STOP); start = 1'b1; end
         ST_FIO_I:  begin idx = IDX_W'(IDX_FIO); arg = ARG_W'(ARG_FIO); start = 1'b1; end
         ST_HARD_I: begin idx = IDX_W'(IDX_IDLE); start = 1'b1; end
         ST_CCSD_W: idx = IDX_W'(IDX_CCSD);
         ST_STOP_W: idx = IDX_W'(IDX_STOP);
         ST_FIO_W:  begin idx = IDX_W'(IDX_FIO); arg = ARG_W'(ARG_FIO); end
         default:   ;
      endcase
   end
endmodule

// File: rtl/tmo_recovery_seq.sv
module tmo_recovery_seq
   import rec_pkg::*;
#(
   parameter int          TW       = 8,
   parameter int          IDX_W    = 6,
   parameter int          ARG_W    = 32,
   parameter int          IDX_CCSD = 60,
   parameter int          IDX_STOP = 12,
   parameter int          IDX_FIO  = 39,
   parameter int          IDX_IDLE = 0,
   parameter logic [31:0] ARG_FIO  = 32'd4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmo_evt,
   input  logic             ien_n,
   input  logic             blk_rsp_seen,
   input  logic             ata_fail,
   input  logic [TW-1:0]    step_limit,
   output logic [IDX_W-1:0] cmd_idx,
   output logic [ARG_W-1:0] cmd_arg,
   output logic             cmd_start,
   input  logic             rsp_valid,
   input  logic             rsp_ok,
   input  logic             rsp_tmo,
   output logic             busy,
   output logic             dev_ready,
   output logic             reinit_req,
   output logic             retry_ok
);
   rec_state_e st_q, st_d;
   logic       waiting, expired, step_bad, step_good, retry_q;

   assign waiting = (st_q == ST_CCSD_W) || (st_q == ST_STOP_W) || (st_q == ST_FIO_W);

   rec_step_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cmd_start),
      .limit  (step_limit),
      .run    (waiting),
      .expired(expired)
   );

   rec_cmd_select #(
      .IDX_W(IDX_W), .ARG_W(ARG_W), .IDX_CCSD(IDX_CCSD), .IDX_STOP(IDX_STOP),
      .IDX_FIO(IDX_FIO), .IDX_IDLE(IDX_IDLE), .ARG_FIO(ARG_FIO)
   ) u_sel (
      .st   (st_q),
      .idx  (cmd_idx),
      .arg  (cmd_arg),
      .start(cmd_start)
   );

   // a response in the expiry cycle still counts
   assign step_bad  = tmo_evt || rsp_tmo || (rsp_valid && !rsp_ok) || (expired && !rsp_valid);
   assign step_good = !step_bad && rsp_valid && rsp_ok;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:     if (tmo_evt) st_d = (!ien_n && blk_rsp_seen) ? ST_CCSD_I : ST_STOP_I;
         ST_CCSD_I:   st_d = tmo_evt ? ST_HARD_I : ST_CCSD_W;
         ST_STOP_I:   st_d = tmo_evt ? ST_HARD_I : ST_STOP_W;
         ST_FIO_I:    st_d = tmo_evt ? ST_HARD_I : ST_FIO_W;
         ST_CCSD_W:   if (step_bad) st_d = ST_HARD_I; else if (step_good) st_d = ST_STOP_I;
         ST_STOP_W:   if (step_bad) st_d = ST_HARD_I; else if (step_good) st_d = ST_FIO_I;
         ST_FIO_W:    if (step_bad) st_d = ST_HARD_I; else if (step_good) st_d = ST_READY_F;
         ST_HARD_I:   st_d = ST_REINIT_F;
         ST_READY_F:  st_d = ST_IDLE;
         ST_REINIT_F: st_d = ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         retry_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         retry_q <= (st_q == ST_IDLE) && ata_fail && !tmo_evt;
      end
   end

   assign busy       = (st_q != ST_IDLE);
   assign dev_ready  = (st_q == ST_READY_F);
   assign reinit_req = (st_q == ST_REINIT_F);
   assign retry_ok   = retry_q;
endmodule

// File: rtl/rec_seq_checker.sv
module rec_seq_checker #(
   parameter int IDX_W    = 6,
   parameter int IDX_FIO  = 39,
   parameter int IDX_IDLE = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_start,
   input logic [IDX_W-1:0] cmd_idx,
   input logic             rsp_valid,
   input logic             rsp_ok,
   input logic             busy,
   input logic             dev_ready,
   input logic             reinit_req,
   input logic             retry_ok
);
   assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> busy);
   assert_pulse_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready || reinit_req) |-> busy);
   assert_reinit_after_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reinit_req |-> $past(cmd_start && cmd_idx == IDX_W'(IDX_IDLE)));
   assert_reinit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reinit_req |=> !reinit_req);
   assert_ready_after_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ready |-> $past(rsp_valid && rsp_ok && cmd_idx == IDX_W'(IDX_FIO)));
   assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ready |=> !dev_ready);
   assert_final_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_ready && reinit_req));
   assert_final_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready || reinit_req) |=> !busy);
   assert_retry_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      retry_ok |-> !busy && !$past(busy));
endmodule

bind tmo_recovery_seq rec_seq_checker #(.IDX_W(IDX_W), .IDX_FIO(IDX_FIO), .IDX_IDLE(IDX_IDLE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_idx(cmd_idx),
   .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .busy(busy), .dev_ready(dev_ready),
   .reinit_req(reinit_req), .retry_ok(retry_ok)
);

// File: tb/sim_tmo_recovery_seq.sv
`timescale 1ns/1ps
module sim_tmo_recovery_seq;
   // response codes per issued step: 0 ok, 1 fail, 2 engine timeout, 3 silent
   typedef struct packed {
      logic        ien_n;
      logic        blk;
      logic [7:0]  codes;   // step k at [2k+1:2k]
      logic [2:0]  n;
      logic [23:0] seq;     // step k at [23-6k -: 6]
      logic        ready;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1, 8'h00, 3'd3, {6'd60, 6'd12, 6'd39, 6'd0}, 1'b1},
      '{1'b1, 1'b1, 8'h00, 3'd2, {6'd12, 6'd39, 6'd0,  6'd0}, 1'b1},
      '{1'b0, 1'b0, 8'h00, 3'd2, {6'd12, 6'd39, 6'd0,  6'd0}, 1'b1},
      '{1'b0, 1'b1, 8'h04, 3'd3, {6'd60, 6'd12, 6'd0,  6'd0}, 1'b0},
      '{1'b1, 1'b0, 8'h02, 3'd2, {6'd12, 6'd0,  6'd0,  6'd0}, 1'b0},
      '{1'b1, 1'b0, 8'h0C, 3'd3, {6'd12, 6'd39, 6'd0,  6'd0}, 1'b0},
      '{1'b0, 1'b1, 8'h03, 3'd2, {6'd60, 6'd0,  6'd0,  6'd0}, 1'b0},
      '{1'b1, 1'b1, 8'h04, 3'd3, {6'd12, 6'd39, 6'd0,  6'd0}, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic tmo_evt = 0, ien_n = 1, blk_rsp_seen = 0, ata_fail = 0;
   logic [7:0] step_limit = 8'd5;
   logic [5:0] cmd_idx;
   logic [31:0] cmd_arg;
   logic cmd_start, rsp_valid = 0, rsp_ok = 0, rsp_tmo = 0;
   logic busy, dev_ready, reinit_req, retry_ok;
   int checks = 0, errors = 0, cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tmo_recovery_seq u0 (
      .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .ien_n(ien_n), .blk_rsp_seen(blk_rsp_seen),
      .ata_fail(ata_fail), .step_limit(step_limit), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
      .cmd_start(cmd_start), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_tmo(rsp_tmo),
      .busy(busy), .dev_ready(dev_ready), .reinit_req(reinit_req), .retry_ok(retry_ok)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // runs one recovery; returns issued indices, count, outcome, busy-hold flag
   task automatic run_seq(input logic [7:0] codes, output logic [23:0] seq, output int n,
                          output logic ready, output logic busy_good, output logic arg_good);
      int pend = 0;
      logic [1:0] code = 2'd0;
      logic done = 0;
      seq = '0; n = 0; ready = 0; busy_good = 1; arg_good = 1;
      tmo_evt = 1'b1;
      for (int it = 0; it < 60 && !done; it++) begin
         @(negedge clk);
         tmo_evt = 1'b0; rsp_valid = 0; rsp_ok = 0; rsp_tmo = 0;
         if (pend == 1) begin
            if (code == 2'd2) rsp_tmo = 1'b1;
            else begin rsp_valid = 1'b1; rsp_ok = (code == 2'd0); end
         end
         if (pend > 0) pend--;
         if (!busy) busy_good = 0;
         if (cmd_start) begin
            if (n < 4) seq[23-6*n -: 6] = cmd_idx;
            if (cmd_arg !== ((cmd_idx == 6'd39) ? 32'd4 : 32'd0)) arg_good = 0;
            code = codes[2*(n%4) +: 2];
            if (cmd_idx != 6'd0 && code != 2'd3) pend = 2;
            n++;
         end
         if (dev_ready || reinit_req) begin ready = dev_ready; done = 1; end
      end
      if (!done) check("R6 sequence ended", 0, 1);
      @(negedge clk);
      rsp_valid = 0; rsp_ok = 0; rsp_tmo = 0;
      if (busy) busy_good = 0;
   endtask

   initial begin : watchdog
      #200000;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [23:0] seq;
      int n, t1, t2;
      logic ready, bg, ag, saw;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 start", cmd_start, 0);
      check("R1 pulses", {dev_ready, reinit_req, retry_ok}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after reset", {busy, cmd_start}, 0);

      // table walk: R2 R3 R4 R5 R6 R7 R10
      for (int v = 0; v < NV; v++) begin
         ien_n = VECS[v].ien_n; blk_rsp_seen = VECS[v].blk;
         run_seq(VECS[v].codes, seq, n, ready, bg, ag);
         check($sformatf("R2/R3/R6 vec%0d order", v), seq, VECS[v].seq);
         check($sformatf("R6 vec%0d count", v), n, VECS[v].n);
         check($sformatf("R5 vec%0d outcome", v), ready, VECS[v].ready);
         check($sformatf("R10 vec%0d busy", v), bg, 1);
         check($sformatf("R4 vec%0d arg", v), ag, 1);
         repeat (2) @(negedge clk);
      end

      // R7 step_limit 0: silent stop-transmission, CMD0 two cycles later
      step_limit = 8'd0; ien_n = 1; t1 = 0; t2 = 0;
      tmo_evt = 1;
      for (int it = 0; it < 20; it++) begin
         @(negedge clk); tmo_evt = 0;
         if (cmd_start && cmd_idx == 6'd12) t1 = cyc;
         if (cmd_start && cmd_idx == 6'd0) t2 = cyc;
      end
      check("R7 expiry gap", t2 - t1, 2);
      step_limit = 8'd5;

      // R8 second timeout while waiting on stop-transmission
      tmo_evt = 1; @(negedge clk); tmo_evt = 0;
      check("R3 first idx", cmd_idx, 12);
      @(negedge clk); tmo_evt = 1; @(negedge clk); tmo_evt = 0;
      check("R8 escalate start", cmd_start, 1);
      check("R8 escalate idx", cmd_idx, 0);
      @(negedge clk);
      check("R6 reinit pulse", reinit_req, 1);
      @(negedge clk);
      check("R10 busy released", busy, 0);

      // R9 ata_fail while idle
      ata_fail = 1; @(negedge clk); ata_fail = 0;
      check("R9 retry pulse", retry_ok, 1);
      check("R9 no command", {cmd_start, busy}, 0);
      @(negedge clk);
      check("R9 retry one cycle", retry_ok, 0);

      // R9 ata_fail ignored while busy
      saw = 0;
      tmo_evt = 1; @(negedge clk); tmo_evt = 0;
      ata_fail = 1;
      for (int it = 0; it < 12; it++) begin
         @(negedge clk);
         if (retry_ok) saw = 1;
         if (!busy) ata_fail = 0;
      end
      ata_fail = 0;
      check("R9 ignored while busy", saw, 0);
      repeat (3) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule